// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block settles conditional branches while the branch sits in the decode stage of a five-stage in-order pipeline. Without it, the program counter is only updated at the end of the memory stage, and each branch costs three cycles: one repeated fetch and two idle slots. Moving the decision into decode cuts the penalty for a taken branch to one squashed slot. An untaken branch costs nothing.

Each cycle the unit receives the instruction word held between fetch and decode, the incremented PC that travels with it, and the two register values that the register file returns for the source fields. A dedicated adder adds the sign-extended 16-bit offset to the incremented PC. A zero detector examines the first source register. Both run on every instruction, whether or not it is a branch. When a zero-test branch is taken, the redirect flag and target are returned to fetch combinationally in the same cycle. The unit then turns the instruction that arrives behind the branch into a no-op. It also loads the decode/execute register with the instruction, both operands, the extended offset and the incremented PC.

Bit numbering follows the big-endian convention. Bit 0 is the most significant bit of the 32-bit word: bits 0..5 hold the opcode, bits 6..10 the tested register, bits 11..15 the second register and bits 16..31 the offset.

Top module: `brz_decode_resolve`

## Requirements
- R1: While reset is high and at the first edge after it, squash_slot is 0 and every decode/execute output (ex_ir, ex_a, ex_b, ex_imm, ex_npc) is 0.
- R2: redirect_pc equals id_npc plus the offset in bits 16..31, sign-extended by copying bit 16, with wraparound modulo 2^32. It is produced for every unsquashed instruction, branch or not.
- R3: Opcode 6'h04 in bits 0..5 (branch-if-zero) asserts redirect in the same cycle exactly when the register selected by bits 6..10 (ra_val) is zero.
- R4: Opcode 6'h05 in bits 0..5 (branch-if-not-zero) asserts redirect in the same cycle exactly when ra_val is nonzero.
- R5: No other opcode asserts redirect, whatever the register values are.
- R6: ra_idx carries bits 6..10 and rb_idx carries bits 11..15 of id_instr, combinationally.
- R7: In the cycle after redirect is asserted, the instruction in decode is squashed. redirect is 0 even if that instruction is a taken branch, squash_slot is 1, and at the next edge ex_ir, ex_a, ex_b and ex_imm load 0 (the no-op). After an untaken branch, squash_slot is 0.
- R8: For an unsquashed instruction, the next clock edge loads ex_ir with id_instr, ex_a with ra_val, ex_b with rb_val, ex_imm with the sign-extended offset and ex_npc with id_npc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_instr | input | 32 | Instruction word in decode |
| id_npc | input | AW | Incremented PC of that instruction |
| ra_val | input | DW | Register file value for bits 6..10 |
| rb_val | input | DW | Register file value for bits 11..15 |
| ra_idx | output | 5 | Register index from bits 6..10 |
| rb_idx | output | 5 | Register index from bits 11..15 |
| redirect | output | 1 | Fetch takes redirect_pc this cycle |
| redirect_pc | output | AW | Branch target from the decode adder |
| squash_slot | output | 1 | Instruction now in decode is being squashed |
| ex_ir | output | 32 | Decode/execute instruction |
| ex_a | output | DW | Decode/execute first operand |
| ex_b | output | DW | Decode/execute second operand |
| ex_imm | output | AW | Decode/execute extended offset |
| ex_npc | output | AW | Decode/execute incremented PC |

## Verification
The bench feeds a taken branch-if-zero and then places a second branch that would be taken in the wrong-path slot. A unit that forgot to squash would redirect twice and send a live instruction into execute. Backward offsets test the sign copy from bit 16 and the address wraparound. Getting either wrong sends fetch forward or to a truncated address. Each branch kind is also applied with the opposite register condition, and a non-branch opcode is applied with a zero register, to catch an inverted or missing opcode qualifier. Field extraction is checked with distinct register numbers in both index fields, so a swapped or shifted big-endian field shows up at once.

// File: rtl/brz_pkg.sv
package brz_pkg;
  localparam int INSTR_W = 32;
  localparam int OFF_W   = 16;
  localparam logic [5:0] OP_BR_IFZ  = 6'h04;
  localparam logic [5:0] OP_BR_IFNZ = 6'h05;
  localparam logic [INSTR_W-1:0] NOP_WORD = '0;

  typedef enum logic [1:0] {BK_NONE, BK_IFZ, BK_IFNZ} br_kind_e;

  // bit 0 (MSB) .. bit 31 (LSB)
  typedef struct packed {
    logic [5:0]       op;   // bits 0..5
    logic [4:0]       ra;   // bits 6..10
    logic [4:0]       rb;   // bits 11..15
    logic [OFF_W-1:0] off;  // bits 16..31
  } ifield_t;
endpackage

// File: rtl/brz_field_split.sv
module brz_field_split
  import brz_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output logic [4:0]         ra,
  output logic [4:0]         rb,
  output br_kind_e           kind,
  output logic [AW-1:0]      off_x
);
  ifield_t f;
  assign f  = ifield_t'(instr);
  assign ra = f.ra;
  assign rb = f.rb;

  always_comb begin
    unique case (f.op)
      OP_BR_IFZ:  kind = BK_IFZ;
      OP_BR_IFNZ: kind = BK_IFNZ;
      default:    kind = BK_NONE;
    endcase
  end

  generate
    if (AW > OFF_W) begin : g_ext
      assign off_x = {{(AW-OFF_W){f.off[OFF_W-1]}}, f.off};
    end else begin : g_fit
      assign off_x = f.off[AW-1:0];
    end
  endgenerate
endmodule

// File: rtl/brz_target_add.sv
module brz_target_add #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] npc,
  input  logic [AW-1:0] off_x,
  output logic [AW-1:0] target
);
  assign target = npc + off_x;
endmodule

// File: rtl/brz_zero_test.sv
module brz_zero_test
  import brz_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] val,
  input  br_kind_e      kind,
  output logic          take
);
  logic is_zero;
  assign is_zero = (val == '0);
  always_comb begin
    unique case (kind)
      BK_IFZ:  take = is_zero;
      BK_IFNZ: take = !is_zero;
      default: take = 1'b0;
    endcase
  end

  // R3
  ifz_take_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == BK_IFZ && val == '0) |-> take);
  // R4
  ifnz_take_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == BK_IFNZ && val != '0) |-> take);
  // R5
  nonbranch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == BK_NONE) |-> !take);
endmodule

// File: rtl/brz_decode_resolve.sv
module brz_decode_resolve
  import brz_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] id_instr,
  input  logic [AW-1:0]      id_npc,
  input  logic [DW-1:0]      ra_val,
  input  logic [DW-1:0]      rb_val,
  output logic [4:0]         ra_idx,
  output logic [4:0]         rb_idx,
  output logic               redirect,
  output logic [AW-1:0]      redirect_pc,
  output logic               squash_slot,
  output logic [INSTR_W-1:0] ex_ir,
  output logic [DW-1:0]      ex_a,
  output logic [DW-1:0]      ex_b,
  output logic [AW-1:0]      ex_imm,
  output logic [AW-1:0]      ex_npc
);
  logic               squash_q;
  logic [INSTR_W-1:0] eff_instr;
  br_kind_e           kind;
  logic [AW-1:0]      off_x;
  logic               take;

  assign eff_instr = squash_q ? NOP_WORD : id_instr;

  // Register indices come from the raw word so the file read is never gated.
  assign ra_idx = id_instr[25:21];
  assign rb_idx = id_instr[20:16];

  logic [4:0] eff_ra, eff_rb;
  brz_field_split #(.AW(AW)) u_split (
    .instr (eff_instr),
    .ra    (eff_ra),
    .rb    (eff_rb),
    .kind  (kind),
    .off_x (off_x)
  );

  brz_target_add #(.AW(AW)) u_add (
    .npc    (id_npc),
    .off_x  (off_x),
    .target (redirect_pc)
  );

  brz_zero_test #(.DW(DW)) u_zt (
    .clk  (clk),
    .rst  (rst),
    .val  (ra_val),
    .kind (kind),
    .take (take)
  );

  assign redirect    = take;
  assign squash_slot = squash_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      squash_q <= 1'b0;
      ex_ir    <= '0;
      ex_a     <= '0;
      ex_b     <= '0;
      ex_imm   <= '0;
      ex_npc   <= '0;
    end else begin
      squash_q <= take;
      ex_ir    <= eff_instr;
      ex_a     <= squash_q ? '0 : ra_val;
      ex_b     <= squash_q ? '0 : rb_val;
      ex_imm   <= off_x;
      ex_npc   <= id_npc;
    end
  end

  // R7
  squash_no_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    squash_slot |-> !redirect);
  // R7
  taken_then_squash_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> squash_slot);
  // R7
  squash_nop_chk: assert property (@(posedge clk) disable iff (rst)
    squash_slot |=> (ex_ir == NOP_WORD));
  // R6
  idx_match_chk: assert property (@(posedge clk) disable iff (rst)
    !squash_slot |-> (eff_ra == ra_idx && eff_rb == rb_idx));
  // R8
  idex_load_chk: assert property (@(posedge clk) disable iff (rst)
    !squash_slot |=> (ex_ir == $past(id_instr) && ex_npc == $past(id_npc)));
endmodule

// File: tb/brz_decode_resolve_bench.sv
`timescale 1ns/1ps
module brz_decode_resolve_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] id_instr = '0, id_npc = '0, ra_val = '0, rb_val = '0;
  logic [4:0]  ra_idx, rb_idx;
  logic        redirect, squash_slot;
  logic [31:0] redirect_pc, ex_ir, ex_a, ex_b, ex_imm, ex_npc;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  brz_decode_resolve u_brz_decode_resolve (
    .clk(clk), .rst(rst), .id_instr(id_instr), .id_npc(id_npc),
    .ra_val(ra_val), .rb_val(rb_val), .ra_idx(ra_idx), .rb_idx(rb_idx),
    .redirect(redirect), .redirect_pc(redirect_pc), .squash_slot(squash_slot),
    .ex_ir(ex_ir), .ex_a(ex_a), .ex_b(ex_b), .ex_imm(ex_imm), .ex_npc(ex_npc)
  );

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] a, logic [4:0] b, logic [15:0] off);
    return {op, a, b, off};
  endfunction

  function automatic logic [31:0] sx(logic [15:0] off);
    return {{16{off[15]}}, off};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] ins, logic [31:0] npc, logic [31:0] av, logic [31:0] bv);
    @(negedge clk);
    id_instr = ins; id_npc = npc; ra_val = av; rb_val = bv;
    #0.5;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    chk("R1 squash", {31'b0, squash_slot}, 0);
    chk("R1 ex_ir", ex_ir, 0);
    chk("R1 ex_a", ex_a, 0);
    chk("R1 ex_b", ex_b, 0);
    chk("R1 ex_imm", ex_imm, 0);
    chk("R1 ex_npc", ex_npc, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_plain_op();
    logic [31:0] w = mk(6'h23, 5'd9, 5'd22, 16'h0040);
    drive(w, 32'h0000_1004, 32'h0, 32'h55);
    chk("R6 ra_idx", {27'b0, ra_idx}, 9);
    chk("R6 rb_idx", {27'b0, rb_idx}, 22);
    chk("R5 no redirect", {31'b0, redirect}, 0);
    chk("R2 target nonbranch", redirect_pc, 32'h0000_1044);
    tick();
    chk("R8 ex_ir", ex_ir, w);
    chk("R8 ex_b", ex_b, 32'h55);
    chk("R8 ex_imm", ex_imm, 32'h40);
    chk("R8 ex_npc", ex_npc, 32'h0000_1004);
    chk("R7 no squash after nonbranch", {31'b0, squash_slot}, 0);
  endtask

  task automatic t_ifz_taken_fwd();
    logic [31:0] w = mk(6'h04, 5'd3, 5'd4, 16'h0010);
    drive(w, 32'h0000_2000, 32'h0, 32'h7);
    chk("R3 ifz taken", {31'b0, redirect}, 1);
    chk("R2 forward target", redirect_pc, 32'h0000_2010);
    tick();
    chk("R8 ex_a", ex_a, 0);
    drive(mk(6'h04, 5'd1, 5'd2, 16'h0100), 32'h0000_2004, 32'h0, 32'hAB);
    chk("R7 squash flag", {31'b0, squash_slot}, 1);
    chk("R7 wrong-path branch ignored", {31'b0, redirect}, 0);
    tick();
    chk("R7 ex_ir nop", ex_ir, 0);
    chk("R7 ex_b cleared", ex_b, 0);
    chk("R7 ex_imm cleared", ex_imm, 0);
    chk("R7 squash ends", {31'b0, squash_slot}, 0);
  endtask

  task automatic t_ifz_untaken();
    drive(mk(6'h04, 5'd5, 5'd0, 16'h0020), 32'h0000_3000, 32'h1, 32'h0);
    chk("R3 ifz untaken", {31'b0, redirect}, 0);
    tick();
    chk("R7 no squash after untaken", {31'b0, squash_slot}, 0);
    chk("R8 ex_a live", ex_a, 32'h1);
  endtask

  task automatic t_ifnz_taken_back();
    drive(mk(6'h05, 5'd7, 5'd8, 16'hFFF0), 32'h0000_4000, 32'h8000_0000, 32'h0);
    chk("R4 ifnz taken", {31'b0, redirect}, 1);
    chk("R2 backward target", redirect_pc, 32'h0000_4000 + sx(16'hFFF0));
    tick();
    chk("R8 ex_imm negative", ex_imm, 32'hFFFF_FFF0);
    drive(mk(6'h23, 5'd1, 5'd1, 16'h0), 32'h0000_4004, 32'h9, 32'h9);
    chk("R7 squash after ifnz", {31'b0, squash_slot}, 1);
    tick();
    chk("R7 ex_a cleared", ex_a, 0);
  endtask

  task automatic t_ifnz_untaken_wrap();
    drive(mk(6'h05, 5'd2, 5'd3, 16'hFFF8), 32'h0000_0004, 32'h0, 32'h0);
    chk("R4 ifnz untaken", {31'b0, redirect}, 0);
    chk("R2 wraparound", redirect_pc, 32'hFFFF_FFFC);
    tick();
  endtask

  task automatic t_other_zero();
    drive(mk(6'h06, 5'd0, 5'd0, 16'h0004), 32'h0000_5000, 32'h0, 32'h0);
    chk("R5 opcode 06 zero reg", {31'b0, redirect}, 0);
    drive(mk(6'h24, 5'd0, 5'd0, 16'h0004), 32'h0000_5004, 32'h0, 32'h0);
    chk("R5 opcode 24 zero reg", {31'b0, redirect}, 0);
    tick();
    chk("R5 no squash", {31'b0, squash_slot}, 0);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_plain_op();
    t_ifz_taken_fwd();
    t_ifz_untaken();
    t_ifnz_taken_back();
    t_ifnz_untaken_wrap();
    t_other_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule